// File: doc/BRIEF.md
# Processor Reset and Self-Test Sequencer

This block runs power-up initialization for an embedded processor core. It watches the chip reset input and counts how long reset stays asserted. The minimum valid length depends on a clock-mode input, which selects either a 1x clock or a 2x clock. While reset is high it keeps sampling two configuration straps: one enables the internal self-test and one selects emulation mode. The straps hold the values they had on the last clock cycle of reset.

After a valid reset release the block starts one of three paths:
- **Emulation:** it floats all outputs.
- **Self-test enabled:** it runs the internal self-test phase, then the external bus confidence phase.
- **Self-test disabled:** it runs the bus confidence phase only.

Each phase has its own start pulse to a test engine outside the block. The block then waits as long as needed for that engine's done and pass signals. A failure flag shows the progress of each phase. After the bus phase passes, a one-cycle strobe tells the core to start user code. A reset that is released too early sets a sticky error flag, and initialization does not start.

A bus hold handshake also runs while the core is in reset. A hold request raised during reset is granted. A grant that is already held lasts until the request drops, even across reset and initialization.

Top module: `boot_seq`

## Requirements
- R1: With `clkMode`=1 (2x clock), a reset sampled high on at least `SHORT_MIN` rising edges is valid. Fewer edges make it a short reset.
- R2: With `clkMode`=0 (1x clock), a reset sampled high on at least `LONG_MIN` rising edges is valid. Fewer edges make it a short reset.
- R3: After a short reset release, `shortResetErr` goes to 1 on the next cycle. `failOut` stays 0 and no start pulse is issued. `shortResetErr` stays 1 across later resets, valid ones included, until `porN` is taken low.
- R4: One cycle after `resetIn` is sampled high, `failOut`, `floatOut`, `intStart`, `busStart` and `userStart` are all 0. The same values hold right after `porN` is released.
- R5: `clkMode`, `selfTestStrap` and `emuStrap` take effect with the values sampled on the last edge on which `resetIn` was high. Changes after release have no effect.
- R6: With self-test latched at 1 and emulation latched at 0, `intStart` pulses for one cycle in the cycle after release, and `failOut` rises at the same time. The sequencer waits for `intDone` without any time limit.
- R7: An internal pass drops `failOut` for one cycle. Then `busStart` pulses with `failOut` at 1 again. An internal fail keeps `failOut` at 1 and never issues `busStart`.
- R8: With self-test latched at 0, `busStart` pulses in the cycle after release, with `failOut` at 1 and no `intStart`.
- R9: A bus pass gives a one-cycle `userStart` pulse, and `failOut` falls at the same time and stays 0. A bus fail keeps `failOut` at 1 and gives no `userStart`.
- R10: With emulation latched at 1, `floatOut` goes to 1 in the cycle after release. It stays 1 until `resetIn` is sampled high again. No test phase runs and `failOut` stays 0.
- R11: `holdAck` goes to 1 one cycle after `holdReq` is sampled high together with `resetIn`. Once granted, it stays 1 until `holdReq` is sampled low. A request made outside reset while `holdAck` is 0 is not granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porN | input | 1 | Power-on reset, active low, asynchronous; clears the sticky error |
| resetIn | input | 1 | Chip reset request, active high, sampled on `clk` |
| clkMode | input | 1 | 1 = 2x clock mode, 0 = 1x clock mode |
| selfTestStrap | input | 1 | 1 = run the internal self-test before the bus test |
| emuStrap | input | 1 | 1 = enter emulation (float) mode after reset |
| holdReq | input | 1 | Bus hold request |
| intDone | input | 1 | Internal self-test engine finished |
| intPass | input | 1 | Internal self-test result, valid with `intDone` |
| busDone | input | 1 | Bus confidence engine finished |
| busPass | input | 1 | Bus confidence result, valid with `busDone` |
| failOut | output | 1 | Failure indicator |
| holdAck | output | 1 | Bus hold acknowledge |
| floatOut | output | 1 | Output-float enable for emulation mode |
| intStart | output | 1 | One-cycle start pulse to the internal test engine |
| busStart | output | 1 | One-cycle start pulse to the bus test engine |
| userStart | output | 1 | One-cycle strobe to begin user code |
| shortResetErr | output | 1 | Sticky flag for a reset released too early |

## Verification
Some rules are checked by assertions on every cycle:
- the outputs are quiet right after reset is sampled;
- `userStart` lasts one cycle and only follows a bus pass;
- `floatOut` rises only at an emulation release;
- a new hold grant only appears during reset;
- the short-reset flag never clears once set.

Other behaviour can only be shown by the bench scenarios: the exact length boundary in each clock mode, the strap values taken from the last reset cycle, the one-cycle dip of `failOut` between the two phases, and the absence of later start pulses after a failed test or a short reset.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_HALT,
    ST_INT_GO,
    ST_INT_WAIT,
    ST_INT_OK,
    ST_BUS_GO,
    ST_BUS_WAIT,
    ST_USER,
    ST_RUN,
    ST_EMU,
    ST_FAILED
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic markShort;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic released;
    logic lengthOk;
    logic emuSel;
    logic testSel;
  } dpStatus_t;

endpackage

// File: rtl/boot_seq_dp.sv
module boot_seq_dp
  import boot_seq_pkg::*;
#(
  parameter int LONG_MIN  = 10000,
  parameter int SHORT_MIN = 32
) (
  input  logic        clk,
  input  logic        porN,
  input  logic        resetIn,
  input  logic        clkMode,
  input  logic        selfTestStrap,
  input  logic        emuStrap,
  input  logic        holdReq,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status,
  output logic        holdAck,
  output logic        shortResetErr
);

  localparam int CAP_VAL = (LONG_MIN > SHORT_MIN) ? LONG_MIN : SHORT_MIN;
  localparam int CW      = $clog2(CAP_VAL + 1);
  localparam logic [CW-1:0] CAP      = CW'(CAP_VAL);
  localparam logic [CW-1:0] NEED_1X  = CW'(LONG_MIN);
  localparam logic [CW-1:0] NEED_2X  = CW'(SHORT_MIN);

  logic          rstQ;
  logic [CW-1:0] lenCnt;
  logic          modeQ;
  logic          testQ;
  logic          emuQ;
  logic [CW-1:0] needCnt;

  // length counter and strap capture: straps follow the pins while reset is high
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstQ   <= 1'b0;
      lenCnt <= '0;
      modeQ  <= 1'b0;
      testQ  <= 1'b0;
      emuQ   <= 1'b0;
    end else begin
      rstQ <= resetIn;
      if (resetIn) begin
        if (lenCnt != CAP) lenCnt <= lenCnt + 1'b1;
        modeQ <= clkMode;
        testQ <= selfTestStrap;
        emuQ  <= emuStrap;
      end else begin
        lenCnt <= '0;
      end
    end
  end

  assign needCnt         = modeQ ? NEED_2X : NEED_1X;
  assign status.released = rstQ & ~resetIn;
  assign status.lengthOk = (lenCnt >= needCnt);
  assign status.emuSel   = emuQ;
  assign status.testSel  = testQ;

  // sticky error, cleared only by power-on reset
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) shortResetErr <= 1'b0;
    else if (strobe.markShort) shortResetErr <= 1'b1;
  end

  // hold handshake: new grants only in reset, held grants kept until request drops
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) holdAck <= 1'b0;
    else holdAck <= holdReq & (resetIn | holdAck);
  end

  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!porN)
    $past(shortResetErr) |-> shortResetErr);

  assert_ack_needs_req_R11: assert property (@(posedge clk) disable iff (!porN)
    holdAck |-> $past(holdReq));

  assert_new_grant_in_reset_R11: assert property (@(posedge clk) disable iff (!porN)
    $rose(holdAck) |-> $past(resetIn));

endmodule

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
(
  input  logic        clk,
  input  logic        porN,
  input  logic        resetIn,
  input  dpStatus_t   status,
  input  logic        intDone,
  input  logic        intPass,
  input  logic        busDone,
  input  logic        busPass,
  output ctrlStrobe_t strobe,
  output logic        failOut,
  output logic        floatOut,
  output logic        intStart,
  output logic        busStart,
  output logic        userStart
);

  seqState_t state;
  seqState_t nxt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) state <= ST_RESET;
    else state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_RESET: begin
        if (status.released) begin
          if (!status.lengthOk) begin
            nxt              = ST_HALT;
            strobe.markShort = 1'b1;
          end else if (status.emuSel) begin
            nxt = ST_EMU;
          end else if (status.testSel) begin
            nxt = ST_INT_GO;
          end else begin
            nxt = ST_BUS_GO;
          end
        end
      end
      ST_INT_GO:   nxt = ST_INT_WAIT;
      ST_INT_WAIT: if (intDone) nxt = intPass ? ST_INT_OK : ST_FAILED;
      ST_INT_OK:   nxt = ST_BUS_GO;
      ST_BUS_GO:   nxt = ST_BUS_WAIT;
      ST_BUS_WAIT: if (busDone) nxt = busPass ? ST_USER : ST_FAILED;
      ST_USER:     nxt = ST_RUN;
      default:     nxt = state;
    endcase
    if (resetIn) nxt = ST_RESET;
  end

  assign failOut   = state inside {ST_INT_GO, ST_INT_WAIT, ST_BUS_GO, ST_BUS_WAIT, ST_FAILED};
  assign floatOut  = (state == ST_EMU);
  assign intStart  = (state == ST_INT_GO);
  assign busStart  = (state == ST_BUS_GO);
  assign userStart = (state == ST_USER);

  assert_quiet_after_reset_R4: assert property (@(posedge clk) disable iff (!porN)
    $past(resetIn) |-> !(failOut || floatOut || intStart || busStart || userStart));

  assert_user_single_R9: assert property (@(posedge clk) disable iff (!porN)
    userStart |=> !userStart);

  assert_user_after_pass_R9: assert property (@(posedge clk) disable iff (!porN)
    userStart |-> $past(busDone && busPass));

  assert_float_entry_R10: assert property (@(posedge clk) disable iff (!porN)
    $rose(floatOut) |-> $past(status.released && status.lengthOk && status.emuSel));

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int LONG_MIN  = 10000,
  parameter int SHORT_MIN = 32
) (
  input  logic clk,
  input  logic porN,
  input  logic resetIn,
  input  logic clkMode,
  input  logic selfTestStrap,
  input  logic emuStrap,
  input  logic holdReq,
  input  logic intDone,
  input  logic intPass,
  input  logic busDone,
  input  logic busPass,
  output logic failOut,
  output logic holdAck,
  output logic floatOut,
  output logic intStart,
  output logic busStart,
  output logic userStart,
  output logic shortResetErr
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  boot_seq_dp #(
    .LONG_MIN (LONG_MIN),
    .SHORT_MIN(SHORT_MIN)
  ) uDp (
    .clk          (clk),
    .porN         (porN),
    .resetIn      (resetIn),
    .clkMode      (clkMode),
    .selfTestStrap(selfTestStrap),
    .emuStrap     (emuStrap),
    .holdReq      (holdReq),
    .strobe       (strobe),
    .status       (status),
    .holdAck      (holdAck),
    .shortResetErr(shortResetErr)
  );

  boot_seq_ctrl uCtrl (
    .clk      (clk),
    .porN     (porN),
    .resetIn  (resetIn),
    .status   (status),
    .intDone  (intDone),
    .intPass  (intPass),
    .busDone  (busDone),
    .busPass  (busPass),
    .strobe   (strobe),
    .failOut  (failOut),
    .floatOut (floatOut),
    .intStart (intStart),
    .busStart (busStart),
    .userStart(userStart)
  );

endmodule

// File: tb/sim_boot_seq.sv
`timescale 1ns/1ps
module sim_boot_seq;

  localparam int LMIN = 300;
  localparam int SMIN = 32;

  logic clk = 1'b0;
  logic porN, resetIn, clkMode, selfTestStrap, emuStrap, holdReq;
  logic intDone, intPass, busDone, busPass;
  logic failOut, holdAck, floatOut, intStart, busStart, userStart, shortResetErr;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;
  bit  expErr   = 1'b0;

  always #2 clk = ~clk;

  boot_seq #(.LONG_MIN(LMIN), .SHORT_MIN(SMIN)) u0 (
    .clk(clk), .porN(porN), .resetIn(resetIn), .clkMode(clkMode),
    .selfTestStrap(selfTestStrap), .emuStrap(emuStrap), .holdReq(holdReq),
    .intDone(intDone), .intPass(intPass), .busDone(busDone), .busPass(busPass),
    .failOut(failOut), .holdAck(holdAck), .floatOut(floatOut),
    .intStart(intStart), .busStart(busStart), .userStart(userStart),
    .shortResetErr(shortResetErr)
  );

  task automatic chkEq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit lenOkF(input bit mode, input int len);
    return len >= (mode ? SMIN : LMIN);
  endfunction

  task automatic quietCheck(input string req);
    chkEq({req, " failOut"},   failOut,   0);
    chkEq({req, " floatOut"},  floatOut,  0);
    chkEq({req, " intStart"},  intStart,  0);
    chkEq({req, " busStart"},  busStart,  0);
    chkEq({req, " userStart"}, userStart, 0);
  endtask

  // reset held for len sampled edges; decoy strap values before and after the last cycles
  task automatic doReset(input bit mode, input int len, input bit st, input bit emu);
    resetIn = 1'b1;
    clkMode = ~mode; selfTestStrap = ~st; emuStrap = ~emu;
    step(1);
    quietCheck("R4 in reset");
    clkMode = mode; selfTestStrap = st; emuStrap = emu;
    step(len - 1);
    resetIn = 1'b0;
    clkMode = ~mode; selfTestStrap = ~st; emuStrap = ~emu;  // R5 late changes ignored
    step(1);
  endtask

  task automatic busPhase(input bit bp, input int dly);
    step(1);
    chkEq("R8 busStart single", busStart, 0);
    step(dly);
    chkEq("R9 fail during bus wait", failOut, 1);
    busDone = 1'b1; busPass = bp;
    step(1);
    busDone = 1'b0; busPass = 1'b0;
    if (bp) begin
      chkEq("R9 userStart on pass", userStart, 1);
      chkEq("R9 fail drops on pass", failOut, 0);
      step(1);
      chkEq("R9 userStart one cycle", userStart, 0);
      chkEq("R9 fail stays low", failOut, 0);
    end else begin
      chkEq("R9 fail held on bus fail", failOut, 1);
      chkEq("R9 no userStart on fail", userStart, 0);
      step(3);
      chkEq("R9 fail still held", failOut, 1);
      chkEq("R9 still no userStart", userStart, 0);
    end
  endtask

  task automatic runScn(input bit mode, input int len, input bit st, input bit emu,
                        input bit ip, input bit bp, input int dly);
    bit ok;
    ok = lenOkF(mode, len);
    doReset(mode, len, st, emu);
    if (!ok) expErr = 1'b1;
    chkEq(mode ? "R1 length check sets err" : "R2 length check sets err", shortResetErr, int'(expErr));
    chkEq("R5 intStart follows latched straps", intStart, int'(ok && !emu && st));
    if (!ok) begin
      quietCheck("R3 short reset");
      step(5);
      quietCheck("R3 short reset later");
      chkEq("R3 err sticky", shortResetErr, 1);
    end else if (emu) begin
      chkEq("R10 float on", floatOut, 1);
      quietCheck_noFloat();
      step(dly + 3);
      chkEq("R10 float held", floatOut, 1);
      chkEq("R10 no bus test", busStart, 0);
      chkEq("R10 fail low", failOut, 0);
    end else if (st) begin
      chkEq("R6 intStart", intStart, 1);
      chkEq("R6 fail raised", failOut, 1);
      step(1);
      chkEq("R6 intStart one cycle", intStart, 0);
      step(dly);
      chkEq("R6 waits with fail high", failOut, 1);
      chkEq("R6 no busStart while waiting", busStart, 0);
      intDone = 1'b1; intPass = ip;
      step(1);
      intDone = 1'b0; intPass = 1'b0;
      if (ip) begin
        chkEq("R7 fail dips after pass", failOut, 0);
        chkEq("R7 busStart not yet", busStart, 0);
        step(1);
        chkEq("R7 busStart", busStart, 1);
        chkEq("R7 fail reasserted", failOut, 1);
        busPhase(bp, dly);
      end else begin
        chkEq("R7 fail held on int fail", failOut, 1);
        step(4);
        chkEq("R7 fail still held", failOut, 1);
        chkEq("R7 no busStart after fail", busStart, 0);
      end
    end else begin
      chkEq("R8 busStart direct", busStart, 1);
      chkEq("R8 fail raised", failOut, 1);
      chkEq("R8 no intStart", intStart, 0);
      busPhase(bp, dly);
    end
  endtask

  task automatic quietCheck_noFloat();
    chkEq("R10 fail low", failOut, 0);
    chkEq("R10 no intStart", intStart, 0);
    chkEq("R10 no busStart", busStart, 0);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    int unsigned seedDummy;
    porN = 1'b0; resetIn = 1'b0; clkMode = 1'b0; selfTestStrap = 1'b0; emuStrap = 1'b0;
    holdReq = 1'b0; intDone = 1'b0; intPass = 1'b0; busDone = 1'b0; busPass = 1'b0;
    seedDummy = $urandom(32'd2024);
    step(3);
    porN = 1'b1;
    step(1);
    quietCheck("R4 after por");
    chkEq("R4 holdAck after por", holdAck, 0);
    chkEq("R3 err clear after por", shortResetErr, 0);

    // directed boundaries
    runScn(1'b1, SMIN,     1'b1, 1'b0, 1'b1, 1'b1, 2);  // R1 exact minimum
    runScn(1'b1, SMIN - 1, 1'b1, 1'b0, 1'b1, 1'b1, 0);  // R1 one short
    runScn(1'b0, LMIN,     1'b0, 1'b0, 1'b1, 1'b1, 1);  // R2 exact, err stays sticky
    runScn(1'b0, LMIN - 1, 1'b0, 1'b0, 1'b1, 1'b1, 0);  // R2 one short
    runScn(1'b1, LMIN - 1, 1'b0, 1'b0, 1'b1, 1'b1, 0);  // R1 long enough in 2x mode

    // R3 clear by power-on reset only
    porN = 1'b0; step(2); porN = 1'b1; step(1);
    expErr = 1'b0;
    chkEq("R3 err cleared by por", shortResetErr, 0);

    runScn(1'b1, 40, 1'b1, 1'b1, 1'b1, 1'b1, 3);   // R10 emulation
    runScn(1'b1, 40, 1'b1, 1'b0, 1'b0, 1'b1, 20);  // R7 internal fail, long wait
    runScn(1'b1, 40, 1'b1, 1'b0, 1'b1, 1'b0, 4);   // R9 bus fail
    runScn(1'b1, 40, 1'b0, 1'b0, 1'b1, 1'b0, 0);   // R8 + R9 bus fail

    // R11 hold handshake
    resetIn = 1'b1; clkMode = 1'b1; selfTestStrap = 1'b0; emuStrap = 1'b0; holdReq = 1'b1;
    step(1);
    chkEq("R11 grant during reset", holdAck, 1);
    step(SMIN + 2);
    resetIn = 1'b0;
    step(3);
    chkEq("R11 grant kept after release", holdAck, 1);
    holdReq = 1'b0;
    step(1);
    chkEq("R11 released when request drops", holdAck, 0);
    holdReq = 1'b1;
    step(3);
    chkEq("R11 no grant outside reset", holdAck, 0);
    resetIn = 1'b1;
    step(1);
    chkEq("R11 pending request granted at reset", holdAck, 1);
    holdReq = 1'b0;
    step(1);
    chkEq("R11 grant drops with request in reset", holdAck, 0);

    // constrained random
    for (int i = 0; i < 30; i++) begin
      bit m, st, em, ip, bp;
      int len, dly;
      m   = 1'($urandom % 2);
      len = (m ? SMIN : LMIN) + int'($urandom % 9) - 4;
      if (len < 2) len = 2;
      st  = 1'($urandom % 2);
      em  = (($urandom % 4) == 0);
      ip  = (($urandom % 5) != 0);
      bp  = (($urandom % 5) != 0);
      dly = int'($urandom % 6);
      runScn(m, len, st, em, ip, bp, dly);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule